// File: doc/BRIEF.md
# Power-fail write-protect sequencer

This controller sits between a host bus and a battery-backed memory array. Two comparator flags drive it. One says the supply has dropped below the deselect threshold. The other says it has dropped further, below the level where the battery must take over. From these flags the block does three things:

- It forces the array's chip-enable, write-strobe and output-enable inactive.
- It selects battery power.
- It holds an active-low reset toward the host.

Both flags are asynchronous to the block clock, so each passes through a synchronizer first.

When the supply comes back above the deselect threshold, the reset stays low for a recovery period. That period is counted in pulses of a slow time base (`tick`). Host strobes are only passed to the array once the count completes. The count starts over if the supply dips again before it finishes. A host cycle that was already active when reset released is not allowed to reach the array. The host must first take chip-enable inactive.

Top module: `pwr_fail_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rst_out_n` stays 0 until a complete recovery period has passed with `pf_low` low.
- R2: SYNC_STAGES clock edges after `pf_low` goes high, `deselect` is 1 and `arr_ce_n`, `arr_we_n` and `arr_oe_n` are all 1. `rst_out_n` goes to 0 on the following edge and stays 0 while power is out of tolerance.
- R3: A write in progress (`ce_n`=0, `we_n`=0) when `pf_low` rises is passed through for SYNC_STAGES-1 further edges. It is then cut off: `arr_we_n` goes to 1 in the same cycle that `deselect` rises.
- R4: After the synchronized `pf_low` falls, `rst_out_n` rises on the edge that samples the REC_TICKS-th `tick` pulse. Ticks that arrive while `pf_low` is still seen high do not count.
- R5: If `pf_low` re-asserts during recovery, the tick count is cleared. A full REC_TICKS ticks are needed after the next fall.
- R6: `bat_sel` equals `so_low` delayed by SYNC_STAGES edges. It drops as soon as `so_low` clears, even while recovery is still running.
- R7: After `rst_out_n` rises, the array strobes stay at 1 until `ce_n` has been sampled high at least once.
- R8: In normal operation (out of reset, re-armed, `pf_low` low), each of `arr_ce_n`, `arr_we_n` and `arr_oe_n` equals its host input, for every combination of the three.
- R9: `rst_out_n` is 0 whenever `bat_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick | input | 1 | One-cycle pulse per slow time-base period |
| pf_low | input | 1 | Asynchronous flag: supply below deselect threshold |
| so_low | input | 1 | Asynchronous flag: supply below battery switchover level |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write strobe, active low |
| oe_n | input | 1 | Host output enable, active low |
| arr_ce_n | output | 1 | Gated chip enable to the array |
| arr_we_n | output | 1 | Gated write strobe to the array |
| arr_oe_n | output | 1 | Gated output enable to the array |
| deselect | output | 1 | Array deselected and write-protected |
| bat_sel | output | 1 | Select battery as array supply |
| rst_out_n | output | 1 | Active-low reset to the host |

## Verification
The checks on battery select and reset assume the comparator ordering: `so_low` is only high while `pf_low` is high. The lower threshold can never be crossed without the upper one. The stimulus keeps this ordering. It raises `pf_low` before `so_low`, and it clears `so_low` no later than `pf_low`. The recovery checks also assume that `tick` is a single-cycle pulse aligned to the block clock. The bench drives it that way and never on two consecutive cycles.

// File: rtl/pfws_pkg.sv
package pfws_pkg;
  typedef enum logic [1:0] {
    PS_PROTECT = 2'd0,
    PS_RECOVER = 2'd1,
    PS_ACTIVE  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pfws_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level flags.
module pfws_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stg
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= '0;
        else        stg[gi] <= stg[gi-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfws_recovery.sv
// Power state sequencer with recovery tick counter.
module pfws_recovery
  import pfws_pkg::*;
#(
  parameter int REC_TICKS = 1311
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pf_s,
  input  logic       tick,
  output pwr_state_e state
);
  localparam int CW = (REC_TICKS > 2) ? $clog2(REC_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(REC_TICKS - 1);

  pwr_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      PS_PROTECT: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        if (!pf_s) st_d = PS_RECOVER;
      end
      PS_RECOVER: begin
        if (pf_s) begin
          st_d   = PS_PROTECT;
          cnt_en = 1'b1;
          cnt_d  = '0;
        end else if (tick) begin
          cnt_en = 1'b1;
          if (cnt_q == LAST) begin
            st_d  = PS_ACTIVE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PS_ACTIVE: begin
        if (pf_s) st_d = PS_PROTECT;
      end
      default: begin
        st_d   = PS_PROTECT;
        cnt_en = 1'b1;
        cnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_PROTECT;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pfws_bus_gate.sv
// Gates host strobes to the array; re-arms only after an idle chip enable.
module pfws_bus_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pf_s,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic arr_ce_n,
  output logic arr_we_n,
  output logic arr_oe_n,
  output logic block
);
  logic armed_q, armed_d, gate;

  always_comb begin
    block   = pf_s | ~active;
    armed_d = active & ~pf_s & (armed_q | ce_n);
    gate    = block | ~armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign arr_ce_n = ce_n | gate;
  assign arr_we_n = we_n | gate;
  assign arr_oe_n = oe_n | gate;
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
  import pfws_pkg::*;
#(
  parameter int REC_TICKS   = 1311,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pf_low,
  input  logic so_low,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic arr_ce_n,
  output logic arr_we_n,
  output logic arr_oe_n,
  output logic deselect,
  output logic bat_sel,
  output logic rst_out_n
);
  logic [1:0] flags_s;
  logic       pf_s;
  pwr_state_e state;

  pfws_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({so_low, pf_low}),
    .q    (flags_s)
  );

  assign pf_s    = flags_s[0];
  assign bat_sel = flags_s[1];

  pfws_recovery #(.REC_TICKS(REC_TICKS)) u_rec (
    .clk  (clk),
    .rst_n(rst_n),
    .pf_s (pf_s),
    .tick (tick),
    .state(state)
  );

  assign rst_out_n = (state == PS_ACTIVE);

  pfws_bus_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (rst_out_n),
    .pf_s    (pf_s),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .arr_ce_n(arr_ce_n),
    .arr_we_n(arr_we_n),
    .arr_oe_n(arr_oe_n),
    .block   (deselect)
  );
endmodule

// File: rtl/pfws_chk.sv
module pfws_chk
  import pfws_pkg::*;
#(
  parameter int REC_TICKS = 1311
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       pf_s,
  input pwr_state_e state,
  input logic       rst_out_n,
  input logic       deselect,
  input logic       bat_sel,
  input logic       arr_ce_n,
  input logic       arr_we_n,
  input logic       arr_oe_n
);
  localparam int CCW = $clog2(REC_TICKS + 1);
  logic [CCW-1:0] seen_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_ticks <= '0;
    else if (state != PS_RECOVER) seen_ticks <= '0;
    else if (tick && !pf_s) seen_ticks <= seen_ticks + 1'b1;
  end

  AST_RST_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (deselect && arr_ce_n && arr_we_n && arr_oe_n)); // R2
  AST_PF_DROPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_s) |=> !rst_out_n); // R2
  AST_PF_CUTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |-> (deselect && arr_we_n)); // R3
  AST_REL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick)); // R4
  AST_REC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (seen_ticks == CCW'(REC_TICKS))); // R5
  AST_BAT_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> !rst_out_n); // R9
endmodule

bind pwr_fail_seq pfws_chk #(.REC_TICKS(REC_TICKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .pf_s     (pf_s),
  .state    (state),
  .rst_out_n(rst_out_n),
  .deselect (deselect),
  .bat_sel  (bat_sel),
  .arr_ce_n (arr_ce_n),
  .arr_we_n (arr_we_n),
  .arr_oe_n (arr_oe_n)
);

// File: tb/pwr_fail_seq_tb.sv
`timescale 1ns/1ps
module pwr_fail_seq_tb;
  localparam int RT = 6;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n, tick, pf_low, so_low, ce_n, we_n, oe_n;
  logic arr_ce_n, arr_we_n, arr_oe_n, deselect, bat_sel, rst_out_n;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_fail_seq #(.REC_TICKS(RT), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pf_low(pf_low), .so_low(so_low),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .arr_oe_n(arr_oe_n),
    .deselect(deselect), .bat_sel(bat_sel), .rst_out_n(rst_out_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    tk(1);
    tick = 1'b0;
  endtask

  task automatic full_recovery(input string req);
    for (int i = 1; i <= RT; i++) begin
      pulse_tick();
      chk(req, rst_out_n, (i == RT) ? 1 : 0);
      tk(1);
    end
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; pf_low = 1'b1; so_low = 1'b1;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tk(3);
    chk("R1 reset rst_out_n", rst_out_n, 0);
    chk("R1 reset arr_we_n", arr_we_n, 1);
    chk("R6 reset bat_sel", bat_sel, 0);
    rst_n = 1'b1;
    tk(SS + 2);
    chk("R6 bat_sel follows so_low", bat_sel, 1);
    chk("R9 reset held on battery", rst_out_n, 0);
    for (int i = 0; i < 3; i++) pulse_tick();   // ignored while out of tolerance
    so_low = 1'b0;
    tk(SS + 1);
    chk("R6 bat_sel released before recovery", bat_sel, 0);
    chk("R1 still in reset", rst_out_n, 0);
    ce_n = 1'b0; we_n = 1'b0;                   // host tries to write early
    pf_low = 1'b0;
    tk(SS + 2);
    chk("R2 deselect during recovery", deselect, 1);
    full_recovery("R4 power-up recovery count");
    chk("R7 strobe held after release", arr_we_n, 1);
    chk("R7 ce held after release", arr_ce_n, 1);
    ce_n = 1'b1; we_n = 1'b1;
    tk(1);
    for (int v = 0; v < 8; v++) begin
      ce_n = v[0]; we_n = v[1]; oe_n = v[2];
      #1;
      chk("R8 passthrough", {arr_oe_n, arr_we_n, arr_ce_n}, v);
      tk(1);
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tk(1);

    // restart sweep with aborted writes
    for (int k = 1; k < RT; k++) begin
      ce_n = 1'b0; we_n = 1'b0;
      #1;
      chk("R8 write active before fail", arr_we_n, 0);
      pf_low = 1'b1;
      tk(SS - 1);
      chk("R3 write still passes in sync", arr_we_n, 0);
      tk(1);
      chk("R3 write cut", arr_we_n, 1);
      chk("R2 deselect", deselect, 1);
      tk(1);
      chk("R2 reset low", rst_out_n, 0);
      ce_n = 1'b1; we_n = 1'b1;
      pf_low = 1'b0;
      tk(SS + 2);
      for (int j = 0; j < k; j++) begin pulse_tick(); tk(1); end
      chk("R5 partial not released", rst_out_n, 0);
      pf_low = 1'b1;
      tk(SS + 2);
      pf_low = 1'b0;
      tk(SS + 2);
      full_recovery("R5 restarted recovery count");
      tk(1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule